// File: doc/BRIEF.md
# Glitch-Free Clock Divider and Gating Tree

This block takes one base clock and produces six derived clocks. Two derived clocks run at fixed ratios. Four have ratios that software picks from small power-of-two sets. Every derived clock passes through its own enable gate. A bypass select can swap the base clock for an alternate clock. The swap goes through a two-sided handshake mux, so no shortened pulse reaches the dividers.

Software changes the setup through one write port. Each write carries a whole control word. The block checks each ratio field against the set that channel allows, keeps the legal fields, and raises `busy`. It then hands the new values to the clock side. There, each channel picks up its new ratio and gate only on the edge that closes its current period. The counter restarts from zero, so the output goes from a full low phase straight into a full high phase of the new setting. If a write arrives while `busy` is high, the block holds it and applies it once the earlier one has landed. A held write may itself be replaced by a later one.

Top module: `clk_div_gate_tree`

## Requirements
- R1: After reset, `busy` is low and bypass is off. Every channel is enabled at its smallest legal ratio: ch0 divides by 2, ch1 by 4, ch2, ch3 and ch4 by 1, and ch5 by 2.
- R2: ch0 always divides by 2 and ch1 always divides by 4. Any value written to their fields leaves them unchanged.
- R3: Bits `wr_data[3k+2:3k]` hold the base-2 log of the ratio for channel k. The legal codes are 0 to 4 for ch2, 0 to 1 for ch3, 0 to 2 for ch4, and 1 to 2 for ch5. A legal code changes the period of `clk_out[k]` to 2^code source cycles.
- R4: A code outside a channel's legal set is ignored, and that channel keeps its previous ratio.
- R5: Bit `wr_data[18+k]` gates channel k. Writing 0 holds `clk_out[k]` low. Writing 1 lets it toggle.
- R6: Bit `wr_data[24]` set to 1 makes `clk_byp` the source of every channel. Set to 0, the source is `clk_base`. The two sources are never enabled together.
- R7: A ratio or gate change takes effect only on the edge that ends the channel's current period. The counter then restarts from zero, so no high pulse is shorter than the shorter of the old and new high phases.
- R8: For ratios of 2 or more, the output is high for exactly half the period. At ratio 1 it follows the selected source.
- R9: `busy` is high from the first `clk_base` edge after an accepted write until every channel has taken the new setting.
- R10: A write that arrives while `busy` is high is held and applied after the earlier one completes. The final outputs reflect the held write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Normal source clock; also clocks the write port |
| clk_byp | input | 1 | Alternate source clock used under bypass |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on `clk_base` |
| wr_data | input | 25 | Control word: ratio codes, gate bits, bypass bit |
| busy | output | 1 | High while a write (or a held write) is being applied |
| clk_out | output | 6 | Derived clocks, one bit per channel |

## Verification
The bench measures period and high time directly at each output. A design that changes ratio mid-period, or restarts the counter badly, shows up as a wrong period or a shortened pulse. A short-pulse monitor watches the output while a slow ratio gives way to a fast one, and catches any runt produced at the handover. Illegal codes are written to the fixed channels and to the restricted channels, including code 0 on a channel whose smallest ratio is 2. A design that accepts them shows the wrong period. Two writes back to back check that the second one is held and not dropped, and that `busy` does not dip low between the two applications.

// File: rtl/clk_div_gate_tree.sv
module clk_div_gate_tree #(
  parameter int NCH  = 6,
  parameter int LW   = 3,
  parameter int MAXL = 4,
  parameter logic [NCH*(MAXL+1)-1:0] MASKS =
    {5'b00110, 5'b00111, 5'b00011, 5'b11111, 5'b00100, 5'b00010},
  localparam int DW = NCH*LW + NCH + 1
) (
  input  logic           clk_base,
  input  logic           clk_byp,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic           busy,
  output logic [NCH-1:0] clk_out
);
  localparam int CW    = MAXL;
  localparam int EN_LO = NCH*LW;

  function automatic logic ok_l(input int k, input logic [LW-1:0] l);
    if (int'(l) > MAXL) return 1'b0;
    return MASKS[k*(MAXL+1) + int'(l)];
  endfunction

  function automatic logic [LW-1:0] low_l(input int k);
    logic [LW-1:0] r;
    r = '0;
    for (int i = MAXL; i >= 0; i--)
      if (MASKS[k*(MAXL+1) + i]) r = LW'(i);
    return r;
  endfunction

  logic [NCH-1:0][LW-1:0] sh_l;
  logic [NCH-1:0]         sh_en;
  logic                   sh_byp, req_t, ak1, ak2, hold_v, ack_t;
  logic [DW-1:0]          hold_d;

  wire           inflight = req_t ^ ak2;
  wire           take     = !inflight && (hold_v || wr_en);
  wire [DW-1:0]  nd       = hold_v ? hold_d : wr_data;
  assign busy = inflight | hold_v;

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) sh_l[k] <= low_l(k);
      sh_en  <= '1;
      sh_byp <= 1'b0;
      req_t  <= 1'b0;
      ak1    <= 1'b0;
      ak2    <= 1'b0;
      hold_v <= 1'b0;
      hold_d <= '0;
    end else begin
      ak1 <= ack_t;
      ak2 <= ak1;
      if (take) begin
        for (int k = 0; k < NCH; k++)
          if (ok_l(k, nd[k*LW +: LW])) sh_l[k] <= nd[k*LW +: LW];
        sh_en  <= nd[EN_LO +: NCH];
        sh_byp <= nd[DW-1];
        req_t  <= ~req_t;
      end
      if (wr_en && (inflight || hold_v)) begin
        hold_d <= wr_data;
        hold_v <= 1'b1;
      end else if (take) hold_v <= 1'b0;
    end

  // source mux: each side arms only after the other has let go
  logic base_sel, base_arm, byp_sel, byp_arm, src;

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n) base_sel <= 1'b1;
    else        base_sel <= !sh_byp && !byp_arm;
  always_ff @(negedge clk_base or negedge rst_n)
    if (!rst_n) base_arm <= 1'b1;
    else        base_arm <= base_sel;
  always_ff @(posedge clk_byp or negedge rst_n)
    if (!rst_n) byp_sel <= 1'b0;
    else        byp_sel <= sh_byp && !base_arm;
  always_ff @(negedge clk_byp or negedge rst_n)
    if (!rst_n) byp_arm <= 1'b0;
    else        byp_arm <= byp_sel;

  assign src = (clk_base & base_arm) | (clk_byp & byp_arm);

  logic                   rq1, rq2, rq_seen;
  logic [NCH-1:0]         pend_w;
  logic [NCH-1:0][LW-1:0] cur_l;
  wire                    nreq = rq2 ^ rq_seen;

  always_ff @(posedge src or negedge rst_n)
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0; rq_seen <= 1'b0; ack_t <= 1'b0;
    end else begin
      rq1     <= req_t;
      rq2     <= rq1;
      rq_seen <= rq2;
      if (!nreq && pend_w == '0) ack_t <= rq_seen;
    end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [LW-1:0] l_q;
    logic          en_q, pend, ph, en_l;
    logic [CW-1:0] cnt;
    logic [CW:0]   span_q, span_n;

    assign span_q = (CW+1)'(1) << l_q;
    wire           wrap = ({1'b0, cnt} == span_q - 1'b1);
    wire           load = wrap && pend;
    wire [LW-1:0]  nl   = load ? sh_l[k]  : l_q;
    wire           nen  = load ? sh_en[k] : en_q;
    wire [CW-1:0]  ncnt = wrap ? '0 : cnt + 1'b1;
    assign span_n = (CW+1)'(1) << nl;

    always_ff @(posedge src or negedge rst_n)
      if (!rst_n) begin
        l_q <= low_l(k); en_q <= 1'b1; pend <= 1'b0; cnt <= '0; ph <= 1'b0;
      end else begin
        l_q  <= nl;
        en_q <= nen;
        cnt  <= ncnt;
        ph   <= nen && ({1'b0, ncnt} < (span_n >> 1));
        pend <= nreq ? 1'b1 : (wrap ? 1'b0 : pend);
      end

    always_latch
      if (!src) en_l = en_q;

    assign clk_out[k] = (l_q == '0) ? (src & en_l) : ph;
    assign pend_w[k]  = pend;
    assign cur_l[k]   = l_q;
  end
endmodule

// File: rtl/clk_div_gate_tree_chk.sv
module clk_div_gate_tree_chk #(
  parameter int NCH  = 6,
  parameter int LW   = 3,
  parameter int MAXL = 4,
  parameter logic [NCH*(MAXL+1)-1:0] MASKS = '1
) (
  input logic                   clk_base,
  input logic                   src,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   busy,
  input logic                   hold_v,
  input logic                   base_arm,
  input logic                   byp_arm,
  input logic [NCH-1:0][LW-1:0] cur_l,
  input logic [NCH-1:0]         pend_w
);
  assert_busy_after_write_R9: assert property (@(posedge clk_base) disable iff (!rst_n)
    wr_en |=> busy);

  assert_held_write_kept_R10: assert property (@(posedge clk_base) disable iff (!rst_n)
    (wr_en && busy) |=> hold_v);

  assert_single_source_R6: assert property (@(posedge clk_base) disable iff (!rst_n)
    !(base_arm && byp_arm));

  for (genvar k = 0; k < NCH; k++) begin : g_ck
    assert_ratio_legal_R4: assert property (@(posedge src) disable iff (!rst_n)
      (int'(cur_l[k]) <= MAXL) && MASKS[k*(MAXL+1) + int'(cur_l[k]) % (MAXL+1)]);

    assert_change_only_when_pending_R7: assert property (@(posedge src) disable iff (!rst_n)
      !$stable(cur_l[k]) |-> $past(pend_w[k]));
  end
endmodule

bind clk_div_gate_tree clk_div_gate_tree_chk #(
  .NCH(NCH), .LW(LW), .MAXL(MAXL), .MASKS(MASKS)
) u_chk (
  .clk_base(clk_base), .src(src), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .hold_v(hold_v), .base_arm(base_arm), .byp_arm(byp_arm),
  .cur_l(cur_l), .pend_w(pend_w)
);

// File: tb/test_clk_div_gate_tree.sv
`timescale 1ns/1ps
module test_clk_div_gate_tree;
  logic        clk_base = 1'b0, clk_byp = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [24:0] wr_data = '0;
  logic        busy;
  logic [5:0]  clk_out;

  clk_div_gate_tree i_clk_div_gate_tree (
    .clk_base(clk_base), .clk_byp(clk_byp), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .busy(busy), .clk_out(clk_out)
  );

  always #4 clk_base = ~clk_base;
  initial begin #3; forever #10 clk_byp = ~clk_byp; end

  int nchk = 0, nfail = 0;

  typedef struct packed {
    logic [3:0] tag; logic [3:0] ch; logic [3:0] code;
    logic en; logic byp; logic [7:0] per; logic [7:0] hi;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{4'd3, 4'd2, 4'd3, 1'b1, 1'b0, 8'd64,  8'd32},  // R3 ch2 /8
    '{4'd3, 4'd2, 4'd4, 1'b1, 1'b0, 8'd128, 8'd64},  // R3 ch2 /16
    '{4'd4, 4'd2, 4'd5, 1'b1, 1'b0, 8'd128, 8'd64},  // R4 code 5 ignored
    '{4'd3, 4'd3, 4'd1, 1'b1, 1'b0, 8'd16,  8'd8},   // R3 ch3 /2
    '{4'd4, 4'd3, 4'd2, 1'b1, 1'b0, 8'd16,  8'd8},   // R4 ch3 code 2 ignored
    '{4'd3, 4'd4, 4'd2, 1'b1, 1'b0, 8'd32,  8'd16},  // R3 ch4 /4
    '{4'd3, 4'd5, 4'd2, 1'b1, 1'b0, 8'd32,  8'd16},  // R3 ch5 /4
    '{4'd4, 4'd5, 4'd0, 1'b1, 1'b0, 8'd32,  8'd16},  // R4 ch5 code 0 ignored
    '{4'd2, 4'd0, 4'd3, 1'b1, 1'b0, 8'd16,  8'd8},   // R2 ch0 stays /2
    '{4'd2, 4'd1, 4'd1, 1'b1, 1'b0, 8'd32,  8'd16},  // R2 ch1 stays /4
    '{4'd8, 4'd2, 4'd0, 1'b1, 1'b0, 8'd8,   8'd4},   // R8 ch2 /1
    '{4'd8, 4'd3, 4'd0, 1'b1, 1'b0, 8'd8,   8'd4},   // R8 ch3 /1
    '{4'd5, 4'd2, 4'd2, 1'b0, 1'b0, 8'd0,   8'd0},   // R5 ch2 gated off
    '{4'd5, 4'd2, 4'd2, 1'b1, 1'b0, 8'd32,  8'd16},  // R5 ch2 back on
    '{4'd6, 4'd0, 4'd7, 1'b1, 1'b1, 8'd40,  8'd20},  // R6 bypass, ch0 /2
    '{4'd6, 4'd2, 4'd0, 1'b1, 1'b1, 8'd20,  8'd10},  // R6 bypass, ch2 /1
    '{4'd6, 4'd2, 4'd7, 1'b1, 1'b0, 8'd8,   8'd4}    // R6 back to base
  };

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd2: return "R2";  4'd3: return "R3";  4'd4: return "R4";
      4'd5: return "R5";  4'd6: return "R6";  default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input real act, input real exp);
    nchk++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      nfail++;
      $display("FAIL %s: got %0.2f expected %0.2f", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] word(input int ch, input logic [2:0] code,
                                       input logic en, input logic byp);
    logic [24:0] w;
    w = {byp, 6'h3f, {6{3'd7}}};
    w[ch*3 +: 3] = code;
    w[18+ch] = en;
    return w;
  endfunction

  task automatic write(input logic [24:0] d);
    @(negedge clk_base); wr_en = 1'b1; wr_data = d;
    @(negedge clk_base); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk_base); n++; end
    if (busy) begin nchk++; nfail++; $display("FAIL R9: busy stuck, got 1 expected 0"); end
    repeat (10) @(negedge clk_base);
  endtask

  logic [2:0] msel = '0;
  logic       mclk;
  assign mclk = clk_out[msel];
  realtime t0, t1, t2;
  bit      mdone;
  real     m_per, m_hi;

  task measure(input int k);
    msel = k[2:0]; mdone = 0; m_per = 0; m_hi = 0;
    fork
      begin
        @(posedge mclk); @(posedge mclk); @(posedge mclk); t0 = $realtime;
        @(negedge mclk); t1 = $realtime;
        @(posedge mclk); t2 = $realtime; mdone = 1;
      end
      begin #2000; end
    join_any
    disable fork;
    if (mdone) begin m_per = t2 - t0; m_hi = t1 - t0; end
  endtask

  bit      mon = 0;
  realtime rise2, min_hi = 1.0e9;
  always @(posedge clk_out[2]) rise2 = $realtime;
  always @(negedge clk_out[2]) if (mon && ($realtime - rise2) < min_hi) min_hi = $realtime - rise2;

  initial begin
    #(150000 * 8);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_base);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_base);
    chk("R1", busy, 0);
    measure(0); chk("R1", m_per, 16); chk("R1", m_hi, 8);
    measure(1); chk("R1", m_per, 32);
    measure(2); chk("R1", m_per, 8);  chk("R1", m_hi, 4);
    measure(5); chk("R1", m_per, 16);

    for (int i = 0; i < 17; i++) begin
      write(word(int'(VEC[i].ch), VEC[i].code[2:0], VEC[i].en, VEC[i].byp));
      wait_idle();
      measure(int'(VEC[i].ch));
      chk(tname(VEC[i].tag), m_per, real'(VEC[i].per));
      chk(tname(VEC[i].tag), m_hi, real'(VEC[i].hi));
    end

    // R9 / R10: back-to-back writes, second is held and wins
    @(negedge clk_base); wr_en = 1'b1; wr_data = word(2, 3'd1, 1'b1, 1'b0);
    @(negedge clk_base); chk("R9", busy, 1);
    wr_data = word(2, 3'd3, 1'b1, 1'b0);
    @(negedge clk_base); wr_en = 1'b0;
    wait_idle();
    measure(2); chk("R10", m_per, 64); chk("R10", m_hi, 32);

    // R7: slow-to-fast handover produces no short high pulse
    mon = 1; min_hi = 1.0e9;
    write(word(2, 3'd1, 1'b1, 1'b0));
    wait_idle();
    repeat (20) @(negedge clk_base);
    mon = 0;
    chk("R7", min_hi, 8);
    measure(2); chk("R7", m_per, 16);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule